// File: doc/BRIEF.md
# Cipher Engine Command Sequencer

This block sits between a host and a block-cipher engine. The host issues 32-bit command words through one write port. The words wait in a small in-order queue. A sequencer takes them off the queue one at a time and decodes the 6-bit opcode in the top bits of each word.

Five kinds of work are recognised:
- **Block start** keeps the engine busy.
- **Input-address setup** takes the next queue word as an address.
- **Transfer fence** raises a one-cycle acknowledge.
- **Memory copy** takes the next word as an external address and keeps a copy engine busy.
- **Table load** presents the key-table fields for one cycle.

The cipher datapath and the memories are not modelled. A down-counting timer stands in for the engine: it holds busy for a fixed number of cycles per 16-byte block. A second timer stands in for the copy engine: it holds busy for a fixed number of cycles per word. The host reads a three-bit status value. It also has an eight-bit interrupt status register with write-one-to-clear bits, an enable register, and a single interrupt line.

The host is expected to push only while the engine is idle or the queue is empty. The block itself refuses a word only when all five queue slots are taken.

Top module: `cmdq_frontend`

## Requirements
- R1: After reset the status reads engine idle, queue empty and copy idle (value 3'b010). Interrupt status, interrupt enable and the interrupt line are all zero, and no action pulse is raised.
- R2: The opcode sits in bits 31:26. The recognised codes are 0x0E block start, 0x10 input-address setup, 0x11 transfer fence, 0x15 table load and 0x22 memory copy. Any other opcode sets interrupt status bit 4 and is thrown away. The word after it is decoded without a stall.
- R3: Bits 11:0 of a block-start word hold the block count minus one. The engine-busy status bit stays high for exactly 176 cycles per block.
- R4: When engine busy falls after the last block, interrupt status bit 0 is set on that same edge.
- R5: The word that follows an input-address setup word is taken as an operand and never decoded as a command. Its value appears on `src_addr_o`.
- R6: A memory-copy word carries the direction in bit 25 (0 means external to internal RAM, 1 means internal RAM to external). It carries the word count in bits 24:12. The next queue word is the external address.
- R7: Copy busy lasts one cycle per word, and at least one cycle. Interrupt status bit 1 is set as it falls.
- R8: A table-load word carries the table select in bits 25:24, the internal-RAM select in bit 23 and the key-table id in bits 20:17. The id is a marker in bit 20 plus a slot number in bits 19:17. The fields are latched onto the table outputs with a one-cycle `tbl_load_o` pulse.
- R9: A transfer-fence word raises `xfer_ack_o` for one cycle. Words are executed strictly in order, and none leaves the queue while the engine is busy.
- R10: The queue holds at most 5 words. A write to a full queue is dropped and sets interrupt status bit 5, which stays set until cleared.
- R11: Status bit 0 is engine busy, bit 1 is queue empty and bit 2 is copy busy.
- R12: Writing ones to interrupt status clears those bits. A new event wins over a clear in the same cycle. `irq_o` is the OR of status AND enable, so the enable value 0x33 unmasks all four sources.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cq_wr_en | input | 1 | Push one word into the command queue |
| cq_wr_data | input | 32 | Command or operand word |
| irq_clr_we | input | 1 | Write strobe for interrupt-status clear |
| irq_clr_mask | input | 8 | Ones clear the matching interrupt status bits |
| irq_en_we | input | 1 | Write strobe for the interrupt enable register |
| irq_en_data | input | 8 | New interrupt enable value |
| status_o | output | 3 | {copy busy, queue empty, engine busy} |
| irq_stat_o | output | 8 | Interrupt status: bit0 engine done, bit1 copy done, bit4 bad opcode, bit5 queue overflow |
| irq_o | output | 1 | Interrupt request |
| src_addr_o | output | 32 | Last input address operand |
| copy_addr_o | output | 32 | External address of the last memory copy |
| copy_dir_o | output | 1 | Direction of the last memory copy |
| copy_words_o | output | 13 | Word count of the last memory copy |
| tbl_load_o | output | 1 | One-cycle table-load pulse |
| tbl_sel_o | output | 2 | Table select of the last table load |
| tbl_ram_o | output | 1 | Internal-RAM select of the last table load |
| tbl_key_id_o | output | 4 | Key-table id (marker and slot) of the last table load |
| xfer_ack_o | output | 1 | One-cycle transfer-fence acknowledge |

## Verification
The following properties are checked on every cycle:
- The queue count never goes above its depth, and a write to a full queue never moves the write pointer.
- No word leaves the queue while the engine is busy, and the two busy flags are never high together.
- Every fall of either busy flag is paired with its interrupt status bit.
- A write-one clear removes the bits it names unless a new event arrives in the same cycle.
- The sequencer stays in its engine wait until the timer ends.

Other behaviour can only be shown by the directed scenarios:
- the exact busy length for one and for several blocks
- an operand word that looks like a block start but is not executed
- the decoded copy and table fields
- the zero-length copy
- five fence acknowledges after a sixth word was dropped
- recovery after an unknown opcode
- interrupt masking

// File: rtl/cmdq_pkg.sv
package cmdq_pkg;

  localparam int OPC_LSB     = 26;
  localparam int OPC_W       = 6;
  localparam int CMD_W       = 32;

  localparam int MC_DIR_BIT  = 25;
  localparam int MC_CNT_LSB  = 12;
  localparam int MC_CNT_MSB  = MC_DIR_BIT - 1;
  localparam int MC_WORDS_W  = MC_CNT_MSB - MC_CNT_LSB + 1;

  localparam int TB_SEL_LSB  = 24;
  localparam int TB_RAM_BIT  = 23;
  localparam int TB_ID_LSB   = 17;
  localparam int TB_ID_W     = 4;

  localparam int IRQ_W         = 8;
  localparam int IRQ_ENG_DONE  = 0;
  localparam int IRQ_COPY_DONE = 1;
  localparam int IRQ_BAD_OPC   = 4;
  localparam int IRQ_Q_OVF     = 5;

  typedef enum logic [OPC_W-1:0] {
    OPC_BLK_GO    = 6'h0E,
    OPC_ADDR_SET  = 6'h10,
    OPC_FENCE     = 6'h11,
    OPC_TBL_LOAD  = 6'h15,
    OPC_MEM_COPY  = 6'h22
  } opcode_e;

  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_OPND,
    SQ_ENG,
    SQ_COPY
  } seq_state_e;

  typedef struct packed {
    logic [1:0]         sel;
    logic               ram;
    logic [TB_ID_W-1:0] key_id;
  } tbl_fields_t;

endpackage

// File: rtl/cmdq_fifo.sv
module cmdq_fifo #(
  parameter int DEPTH = 5,
  parameter int W     = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] rdata,
  output logic         empty,
  output logic         full,
  output logic         drop
);

  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem_q [DEPTH];
  logic [PW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          push_ok, pop_ok;

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign drop    = push && full;
  assign rdata   = mem_q[rp_q];

  always_comb begin
    wp_d  = wp_q;
    rp_d  = rp_q;
    cnt_d = cnt_q;
    if (push_ok) begin
      wp_d = (wp_q == PW'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
    end
    if (pop_ok) begin
      rp_d = (rp_q == PW'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
    end
    case ({push_ok, pop_ok})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) begin
      mem_q[wp_q] <= wdata;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH)); // R10
  AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push) |=> $stable(wp_q)); // R10

endmodule

// File: rtl/cmdq_busy_timer.sv
module cmdq_busy_timer #(
  parameter int TW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic          busy,
  output logic          done
);

  logic [TW-1:0] cnt_q, cnt_d;
  logic          busy_q, busy_d;

  assign busy = busy_q;
  assign done = busy_q && (cnt_q == TW'(1));

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    if (load) begin
      busy_d = 1'b1;
      cnt_d  = (load_val == '0) ? TW'(1) : load_val;
    end else if (busy_q) begin
      if (cnt_q == TW'(1)) begin
        busy_d = 1'b0;
      end
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
    end
  end

  AST_TMR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && cnt_q > TW'(1)) |=> busy_q); // R3
  AST_TMR_END: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !load) |=> !busy_q); // R3

endmodule

// File: rtl/cmdq_seq.sv
module cmdq_seq
  import cmdq_pkg::*;
#(
  parameter int BLK_W    = 12,
  parameter int CYC_BLK  = 176,
  parameter int CYC_WORD = 1,
  parameter int TW       = 24
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  q_empty,
  input  logic [CMD_W-1:0]      q_head,
  input  logic                  eng_done,
  input  logic                  copy_done,
  output logic                  q_pop,
  output logic                  eng_load,
  output logic [TW-1:0]         eng_len,
  output logic                  copy_load,
  output logic [TW-1:0]         copy_len,
  output logic                  bad_opc,
  output logic [CMD_W-1:0]      src_addr,
  output logic [CMD_W-1:0]      copy_addr,
  output logic                  copy_dir,
  output logic [MC_WORDS_W-1:0] copy_words,
  output tbl_fields_t           tbl,
  output logic                  tbl_load,
  output logic                  xfer_ack
);

  seq_state_e            state_q, state_d;
  logic                  is_copy_q, is_copy_d;
  logic [CMD_W-1:0]      src_q, src_d, caddr_q, caddr_d;
  logic                  cdir_q, cdir_d;
  logic [MC_WORDS_W-1:0] cwords_q, cwords_d;
  tbl_fields_t           tbl_q, tbl_d;
  logic                  tload_q, tload_d;
  logic                  ack_q, ack_d;
  logic [BLK_W:0]        nblk;
  logic [OPC_W-1:0]      opc;

  assign opc      = q_head[CMD_W-1:OPC_LSB];
  assign nblk     = {1'b0, q_head[BLK_W-1:0]} + 1'b1;
  assign eng_len  = TW'(nblk) * TW'(CYC_BLK);
  assign copy_len = TW'(cwords_q) * TW'(CYC_WORD);

  assign src_addr   = src_q;
  assign copy_addr  = caddr_q;
  assign copy_dir   = cdir_q;
  assign copy_words = cwords_q;
  assign tbl        = tbl_q;
  assign tbl_load   = tload_q;
  assign xfer_ack   = ack_q;

  always_comb begin
    state_d   = state_q;
    is_copy_d = is_copy_q;
    src_d     = src_q;
    caddr_d   = caddr_q;
    cdir_d    = cdir_q;
    cwords_d  = cwords_q;
    tbl_d     = tbl_q;
    tload_d   = 1'b0;
    ack_d     = 1'b0;
    q_pop     = 1'b0;
    eng_load  = 1'b0;
    copy_load = 1'b0;
    bad_opc   = 1'b0;
    case (state_q)
      SQ_IDLE: begin
        if (!q_empty) begin
          q_pop = 1'b1;
          case (opc)
            OPC_BLK_GO: begin
              eng_load = 1'b1;
              state_d  = SQ_ENG;
            end
            OPC_ADDR_SET: begin
              is_copy_d = 1'b0;
              state_d   = SQ_OPND;
            end
            OPC_MEM_COPY: begin
              is_copy_d = 1'b1;
              cdir_d    = q_head[MC_DIR_BIT];
              cwords_d  = q_head[MC_CNT_MSB:MC_CNT_LSB];
              state_d   = SQ_OPND;
            end
            OPC_FENCE: begin
              ack_d = 1'b1;
            end
            OPC_TBL_LOAD: begin
              tbl_d.sel    = q_head[TB_SEL_LSB+1:TB_SEL_LSB];
              tbl_d.ram    = q_head[TB_RAM_BIT];
              tbl_d.key_id = q_head[TB_ID_LSB+TB_ID_W-1:TB_ID_LSB];
              tload_d      = 1'b1;
            end
            default: begin
              bad_opc = 1'b1;
            end
          endcase
        end
      end
      SQ_OPND: begin
        if (!q_empty) begin
          q_pop = 1'b1;
          if (is_copy_q) begin
            caddr_d   = q_head;
            copy_load = 1'b1;
            state_d   = SQ_COPY;
          end else begin
            src_d   = q_head;
            state_d = SQ_IDLE;
          end
        end
      end
      SQ_ENG: begin
        if (eng_done) begin
          state_d = SQ_IDLE;
        end
      end
      SQ_COPY: begin
        if (copy_done) begin
          state_d = SQ_IDLE;
        end
      end
      default: state_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= SQ_IDLE;
      is_copy_q <= 1'b0;
      src_q     <= '0;
      caddr_q   <= '0;
      cdir_q    <= 1'b0;
      cwords_q  <= '0;
      tbl_q     <= '0;
      tload_q   <= 1'b0;
      ack_q     <= 1'b0;
    end else begin
      state_q   <= state_d;
      is_copy_q <= is_copy_d;
      src_q     <= src_d;
      caddr_q   <= caddr_d;
      cdir_q    <= cdir_d;
      cwords_q  <= cwords_d;
      tbl_q     <= tbl_d;
      tload_q   <= tload_d;
      ack_q     <= ack_d;
    end
  end

  AST_SEQ_ENG_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SQ_ENG && !eng_done) |=> state_q == SQ_ENG); // R9

endmodule

// File: rtl/cmdq_irq.sv
module cmdq_irq #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set,
  input  logic         clr_we,
  input  logic [W-1:0] clr_mask,
  input  logic         en_we,
  input  logic [W-1:0] en_data,
  output logic [W-1:0] stat,
  output logic         irq
);

  logic [W-1:0] stat_q, stat_d, en_q, en_d, clr_eff;

  assign stat    = stat_q;
  assign irq     = |(stat_q & en_q);
  assign clr_eff = clr_we ? clr_mask : '0;

  always_comb begin
    stat_d = (stat_q & ~clr_eff) | set;
    en_d   = en_we ? en_data : en_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      en_q   <= '0;
    end else begin
      stat_q <= stat_d;
      en_q   <= en_d;
    end
  end

  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we && ((clr_mask & set) == '0)) |=> ((stat_q & $past(clr_mask)) == '0)); // R12
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (set != '0) |=> ((stat_q & $past(set)) == $past(set))); // R12

endmodule

// File: rtl/cmdq_frontend.sv
module cmdq_frontend
  import cmdq_pkg::*;
#(
  parameter int Q_DEPTH  = 5,
  parameter int BLK_W    = 12,
  parameter int CYC_BLK  = 176,
  parameter int CYC_WORD = 1,
  parameter int TMR_W    = 24
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cq_wr_en,
  input  logic [31:0] cq_wr_data,
  input  logic        irq_clr_we,
  input  logic [7:0]  irq_clr_mask,
  input  logic        irq_en_we,
  input  logic [7:0]  irq_en_data,
  output logic [2:0]  status_o,
  output logic [7:0]  irq_stat_o,
  output logic        irq_o,
  output logic [31:0] src_addr_o,
  output logic [31:0] copy_addr_o,
  output logic        copy_dir_o,
  output logic [12:0] copy_words_o,
  output logic        tbl_load_o,
  output logic [1:0]  tbl_sel_o,
  output logic        tbl_ram_o,
  output logic [3:0]  tbl_key_id_o,
  output logic        xfer_ack_o
);

  logic              rst_meta_q, rst_int_n;
  logic [CMD_W-1:0]  q_head;
  logic              q_empty, q_full, q_drop, q_pop;
  logic              eng_load, eng_busy, eng_done;
  logic              copy_load, copy_busy, copy_done;
  logic [TMR_W-1:0]  eng_len, copy_len;
  logic              bad_opc;
  logic [IRQ_W-1:0]  irq_set;
  tbl_fields_t       tbl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_int_n  <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_int_n  <= rst_meta_q;
    end
  end

  cmdq_fifo #(.DEPTH(Q_DEPTH), .W(CMD_W)) u_fifo (
    .clk   (clk),
    .rst_n (rst_int_n),
    .push  (cq_wr_en),
    .wdata (cq_wr_data),
    .pop   (q_pop),
    .rdata (q_head),
    .empty (q_empty),
    .full  (q_full),
    .drop  (q_drop)
  );

  cmdq_seq #(
    .BLK_W(BLK_W), .CYC_BLK(CYC_BLK), .CYC_WORD(CYC_WORD), .TW(TMR_W)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .q_empty    (q_empty),
    .q_head     (q_head),
    .eng_done   (eng_done),
    .copy_done  (copy_done),
    .q_pop      (q_pop),
    .eng_load   (eng_load),
    .eng_len    (eng_len),
    .copy_load  (copy_load),
    .copy_len   (copy_len),
    .bad_opc    (bad_opc),
    .src_addr   (src_addr_o),
    .copy_addr  (copy_addr_o),
    .copy_dir   (copy_dir_o),
    .copy_words (copy_words_o),
    .tbl        (tbl),
    .tbl_load   (tbl_load_o),
    .xfer_ack   (xfer_ack_o)
  );

  cmdq_busy_timer #(.TW(TMR_W)) u_eng_tmr (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .load     (eng_load),
    .load_val (eng_len),
    .busy     (eng_busy),
    .done     (eng_done)
  );

  cmdq_busy_timer #(.TW(TMR_W)) u_copy_tmr (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .load     (copy_load),
    .load_val (copy_len),
    .busy     (copy_busy),
    .done     (copy_done)
  );

  always_comb begin
    irq_set                = '0;
    irq_set[IRQ_ENG_DONE]  = eng_done;
    irq_set[IRQ_COPY_DONE] = copy_done;
    irq_set[IRQ_BAD_OPC]   = bad_opc;
    irq_set[IRQ_Q_OVF]     = q_drop;
  end

  cmdq_irq #(.W(IRQ_W)) u_irq (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .set      (irq_set),
    .clr_we   (irq_clr_we),
    .clr_mask (irq_clr_mask),
    .en_we    (irq_en_we),
    .en_data  (irq_en_data),
    .stat     (irq_stat_o),
    .irq      (irq_o)
  );

  assign status_o     = {copy_busy, q_empty, eng_busy};
  assign tbl_sel_o    = tbl.sel;
  assign tbl_ram_o    = tbl.ram;
  assign tbl_key_id_o = tbl.key_id;

  AST_DONE_ON_FALL: assert property (@(posedge clk) disable iff (!rst_int_n)
    $fell(eng_busy) |-> irq_stat_o[IRQ_ENG_DONE]); // R4
  AST_COPY_ON_FALL: assert property (@(posedge clk) disable iff (!rst_int_n)
    $fell(copy_busy) |-> irq_stat_o[IRQ_COPY_DONE]); // R7
  AST_NO_POP_BUSY: assert property (@(posedge clk) disable iff (!rst_int_n)
    eng_busy |-> !q_pop); // R9
  AST_ONE_BUSY: assert property (@(posedge clk) disable iff (!rst_int_n)
    !(eng_busy && copy_busy)); // R11
  AST_DROP_FULL: assert property (@(posedge clk) disable iff (!rst_int_n)
    q_drop |-> q_full); // R10

endmodule

// File: tb/cmdq_frontend_test.sv
`timescale 1ns/1ps
module cmdq_frontend_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cq_wr_en;
  logic [31:0] cq_wr_data;
  logic        irq_clr_we;
  logic [7:0]  irq_clr_mask;
  logic        irq_en_we;
  logic [7:0]  irq_en_data;
  logic [2:0]  status_o;
  logic [7:0]  irq_stat_o;
  logic        irq_o;
  logic [31:0] src_addr_o;
  logic [31:0] copy_addr_o;
  logic        copy_dir_o;
  logic [12:0] copy_words_o;
  logic        tbl_load_o;
  logic [1:0]  tbl_sel_o;
  logic        tbl_ram_o;
  logic [3:0]  tbl_key_id_o;
  logic        xfer_ack_o;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  cmdq_frontend uut (
    .clk          (clk),
    .rst_n        (rst_n),
    .cq_wr_en     (cq_wr_en),
    .cq_wr_data   (cq_wr_data),
    .irq_clr_we   (irq_clr_we),
    .irq_clr_mask (irq_clr_mask),
    .irq_en_we    (irq_en_we),
    .irq_en_data  (irq_en_data),
    .status_o     (status_o),
    .irq_stat_o   (irq_stat_o),
    .irq_o        (irq_o),
    .src_addr_o   (src_addr_o),
    .copy_addr_o  (copy_addr_o),
    .copy_dir_o   (copy_dir_o),
    .copy_words_o (copy_words_o),
    .tbl_load_o   (tbl_load_o),
    .tbl_sel_o    (tbl_sel_o),
    .tbl_ram_o    (tbl_ram_o),
    .tbl_key_id_o (tbl_key_id_o),
    .xfer_ack_o   (xfer_ack_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic push(input logic [31:0] w);
    @(negedge clk);
    cq_wr_en   = 1'b1;
    cq_wr_data = w;
    @(negedge clk);
    cq_wr_en   = 1'b0;
  endtask

  task automatic w1c(input logic [7:0] m);
    @(negedge clk);
    irq_clr_we   = 1'b1;
    irq_clr_mask = m;
    @(negedge clk);
    irq_clr_we   = 1'b0;
  endtask

  task automatic set_en(input logic [7:0] v);
    @(negedge clk);
    irq_en_we   = 1'b1;
    irq_en_data = v;
    @(negedge clk);
    irq_en_we   = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // sel 0: engine busy, sel 1: copy busy
  task automatic measure_busy(input int sel, output int n);
    int guard;
    guard = 0;
    n = 0;
    while (((sel == 0) ? status_o[0] : status_o[2]) !== 1'b1 && guard < 50) begin
      @(negedge clk);
      guard++;
    end
    while (((sel == 0) ? status_o[0] : status_o[2]) === 1'b1 && guard < 100000) begin
      n++;
      @(negedge clk);
      guard++;
    end
  endtask

  task automatic t_reset();
    check("R1 status", {29'd0, status_o}, 32'h2);
    check("R1 irq status", {24'd0, irq_stat_o}, 32'h0);
    check("R1 irq line", {31'd0, irq_o}, 32'h0);
    check("R1 pulses", {30'd0, tbl_load_o, xfer_ack_o}, 32'h0);
  endtask

  task automatic t_block_one();
    int n;
    set_en(8'h33);
    push(32'h3800_0000);
    measure_busy(0, n);
    check("R3 one block busy", n, 176);
    check("R4 done bit", {31'd0, irq_stat_o[0]}, 32'h1);
    check("R12 irq raised", {31'd0, irq_o}, 32'h1);
    w1c(8'h01);
    check("R12 cleared", {24'd0, irq_stat_o}, 32'h0);
    check("R12 irq dropped", {31'd0, irq_o}, 32'h0);
  endtask

  task automatic t_block_three();
    int n;
    push(32'h3800_0002);
    measure_busy(0, n);
    check("R3 three blocks busy", n, 528);
    check("R4 done bit", {31'd0, irq_stat_o[0]}, 32'h1);
    w1c(8'h01);
  endtask

  task automatic t_addr_setup();
    int seen;
    seen = 0;
    push(32'h4000_0000);
    push(32'h3800_0007);
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (status_o[0] === 1'b1) seen++;
    end
    check("R5 operand value", src_addr_o, 32'h3800_0007);
    check("R5 operand not run", seen, 0);
    check("R5 no events", {24'd0, irq_stat_o}, 32'h0);
    check("R11 queue empty", {31'd0, status_o[1]}, 32'h1);
  endtask

  task automatic t_copy();
    int n;
    push(32'h8A01_0000);
    push(32'h1234_5670);
    measure_busy(1, n);
    check("R7 copy busy length", n, 16);
    check("R6 copy dir", {31'd0, copy_dir_o}, 32'h1);
    check("R6 copy words", {19'd0, copy_words_o}, 32'd16);
    check("R6 copy addr", copy_addr_o, 32'h1234_5670);
    check("R7 copy done bit", {31'd0, irq_stat_o[1]}, 32'h1);
    w1c(8'h02);
    push(32'h8800_0000);
    push(32'hCAFE_0000);
    measure_busy(1, n);
    check("R7 zero-word copy busy", n, 1);
    check("R6 copy dir zero", {31'd0, copy_dir_o}, 32'h0);
    check("R6 copy addr 2", copy_addr_o, 32'hCAFE_0000);
    w1c(8'h02);
  endtask

  task automatic t_table();
    int pulses;
    pulses = 0;
    push(32'h579A_0000);
    for (int i = 0; i < 6; i++) begin
      if (tbl_load_o === 1'b1) pulses++;
      @(negedge clk);
    end
    check("R8 one load pulse", pulses, 1);
    check("R8 table select", {30'd0, tbl_sel_o}, 32'h3);
    check("R8 ram select", {31'd0, tbl_ram_o}, 32'h1);
    check("R8 key id", {28'd0, tbl_key_id_o}, 32'hD);
  endtask

  task automatic t_bad_opcode();
    int n;
    push(32'hFC00_0000);
    push(32'h3800_0000);
    measure_busy(0, n);
    check("R2 next word still runs", n, 176);
    check("R2 bad opcode bit", {31'd0, irq_stat_o[4]}, 32'h1);
    w1c(8'h11);
    check("R12 both cleared", {24'd0, irq_stat_o}, 32'h0);
  endtask

  task automatic t_overflow();
    int acks;
    acks = 0;
    push(32'h3800_0009);
    for (int k = 0; k < 6; k++) push(32'h4400_0000);
    check("R10 overflow bit", {31'd0, irq_stat_o[5]}, 32'h1);
    check("R11 queue not empty", {31'd0, status_o[1]}, 32'h0);
    check("R11 engine busy", {31'd0, status_o[0]}, 32'h1);
    check("R9 no ack while busy", {31'd0, xfer_ack_o}, 32'h0);
    for (int i = 0; i < 1900; i++) begin
      if (xfer_ack_o === 1'b1) acks++;
      @(negedge clk);
    end
    check("R10 five kept, one dropped", acks, 5);
    check("R9 queue drained", {31'd0, status_o[1]}, 32'h1);
    check("R10 overflow sticky", {31'd0, irq_stat_o[5]}, 32'h1);
    w1c(8'h21);
    check("R12 cleared after overflow", {24'd0, irq_stat_o}, 32'h0);
  endtask

  task automatic t_mask();
    set_en(8'h00);
    push(32'hFC00_0000);
    idle(4);
    check("R2 bad opcode flagged", {31'd0, irq_stat_o[4]}, 32'h1);
    check("R12 masked irq low", {31'd0, irq_o}, 32'h0);
    set_en(8'h10);
    check("R12 unmasked irq high", {31'd0, irq_o}, 32'h1);
    w1c(8'h10);
    check("R12 irq low after clear", {31'd0, irq_o}, 32'h0);
    set_en(8'h33);
  endtask

  initial begin
    rst_n        = 1'b0;
    cq_wr_en     = 1'b0;
    cq_wr_data   = '0;
    irq_clr_we   = 1'b0;
    irq_clr_mask = '0;
    irq_en_we    = 1'b0;
    irq_en_data  = '0;
    idle(4);
    rst_n = 1'b1;
    idle(5);
    t_reset();
    t_block_one();
    t_block_three();
    t_addr_setup();
    t_copy();
    t_table();
    t_bad_opcode();
    t_overflow();
    t_mask();
    idle(5);
    report();
  end

  initial begin
    #(5.0 * 150000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: run did not complete");
    report();
  end

endmodule